// File: doc/BRIEF.md
# Command Word-Count Address Generator

This block drives the five low-order address lines that a remote terminal presents to its subsystem memory while a message is in progress. At the start of each message it captures the subaddress and word-count fields of the received command. For the rest of the message the address lines carry one of two things: the captured word-count field, or a running counter of data words. The captured subaddress decides which: an all-zeros or all-ones subaddress marks a mode command.

An in-command flag (active low) marks the phase in which the command is still being handled. In that phase the lines show the word count only during the first data strobe after message start. After that they show the next counter value. Once the flag is released they show the counter itself. A mode command overrides all of this and always shows the word-count field. The counter starts from zero at each message start. It does not advance on the first data strobe. It wraps modulo 2^FIELD_W, which fits a word-count field of zero meaning the full 32 words.

Top module: `wc_addr_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter clears, the captured fields clear and no first strobe is pending. After reset, `addr_o` reads 0.
- R2: The subaddress and word-count fields are captured only on a clock edge with `msg_start` high. Changes to `sa_i` or `wc_i` at any other time have no effect on `addr_o`.
- R3: A captured subaddress of all zeros (0) or all ones (31) is a mode code. Then `addr_o` equals the captured word-count field whatever the state of `in_cmd_n` and `data_stb`.
- R4: For a non-mode subaddress, while `in_cmd_n` is low and `data_stb` is high on the first strobe after message start, `addr_o` equals the captured word-count field.
- R5: For a non-mode subaddress, while `in_cmd_n` is low at any other time, `addr_o` equals (counter + 1) modulo 32.
- R6: For a non-mode subaddress, while `in_cmd_n` is high, `addr_o` equals the counter.
- R7: The counter is 0 after a message start. The first data strobe leaves it at 0. Each later data strobe raises it by exactly one.
- R8: The counter wraps from 31 to 0, and "counter + 1" wraps from 31 to 0 as well.
- R9: When `msg_start` and `data_stb` are high in the same cycle, the start wins. That strobe is ignored and the first-strobe window stays open for the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_start | input | 1 | One-cycle pulse at the start of a new message |
| data_stb | input | 1 | One-cycle strobe per data word transferred |
| in_cmd_n | input | 1 | Low while the command is being handled |
| sa_i | input | FIELD_W | Subaddress field of the received command |
| wc_i | input | FIELD_W | Word-count field of the received command |
| addr_o | output | FIELD_W | Low address lines to subsystem memory |

## Verification
The bench uses the default FIELD_W of 5. This makes the full field space small enough to sweep. Every one of the 32 subaddresses is run with several word counts, so both mode codes and all 30 ordinary subaddresses are covered. Each message runs up to 35 strobes, so the counter and its plus-one view both pass through the wrap at 31. At each step `addr_o` is compared in both phases of the in-command flag, so every selection branch is checked at every counter value.

// File: rtl/wc_addr_pkg.sv
// Package: shared selection type for the word-count address generator.
// Assumes nothing beyond SystemVerilog 2017 enum support.
package wc_addr_pkg;

    // Source chosen for the address lines
    typedef enum logic [1:0] {
        SEL_CMD_WC   = 2'd0,   // captured word-count field
        SEL_CNT_NEXT = 2'd1,   // running count plus one
        SEL_CNT      = 2'd2    // running count
    } addr_sel_e;

endpackage

// File: rtl/wc_field_latch.sv
// Module: wc_field_latch
// Captures the command subaddress and word-count fields on message start.
// It also flags a mode command (subaddress all zeros or all ones).
// Assumes msg_start is a single-cycle pulse synchronous to clk.
module wc_field_latch #(
    parameter int FIELD_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msg_start,
    input  logic [FIELD_W-1:0] sa_i,
    input  logic [FIELD_W-1:0] wc_i,
    output logic [FIELD_W-1:0] wc_q,
    output logic               mode_q
);

    logic [FIELD_W-1:0] sa_q;
    logic               sa_is_mode;

    // Mode detect on the incoming subaddress
    always_comb begin
        sa_is_mode = (&sa_i) | ~(|sa_i);
    end

    // Capture fields at message start, hold for the whole message
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sa_q   <= '0;
            wc_q   <= '0;
            mode_q <= 1'b1;
        end else if (msg_start) begin
            sa_q   <= sa_i;
            wc_q   <= wc_i;
            mode_q <= sa_is_mode;
        end
    end

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_start |=> $stable(wc_q) && $stable(sa_q) && $stable(mode_q)); // R2

    AST_MODE_MATCHES_SA: assert property (@(posedge clk) disable iff (!rst_n)
        msg_start |=> mode_q == ((sa_q == '0) || (sa_q == '1))); // R3

endmodule

// File: rtl/wc_word_counter.sv
// Module: wc_word_counter
// Counts data words within a message. It clears on message start,
// skips the first strobe, and then steps by one on every strobe, wrapping modulo 2^FIELD_W.
// Assumes msg_start has priority over a coincident data strobe.
module wc_word_counter #(
    parameter int FIELD_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msg_start,
    input  logic               data_stb,
    output logic [FIELD_W-1:0] cnt_q,
    output logic               first_q
);

    localparam logic [FIELD_W-1:0] ONE = {{(FIELD_W-1){1'b0}}, 1'b1};

    // Track whether the first strobe of the message is still to come
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
        end else if (msg_start) begin
            first_q <= 1'b1;
        end else if (data_stb) begin
            first_q <= 1'b0;
        end
    end

    // Running count of data words after the first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (msg_start) begin
            cnt_q <= '0;
        end else if (data_stb && !first_q) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    AST_CNT_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        msg_start |=> (cnt_q == '0) && first_q); // R7

    AST_FIRST_STB_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb && first_q && !msg_start) |=> (cnt_q == $past(cnt_q)) && !first_q); // R7

    AST_CNT_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb && !first_q && !msg_start) |=> cnt_q == FIELD_W'($past(cnt_q) + ONE)); // R8

    AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_stb && !msg_start) |=> $stable(cnt_q) && $stable(first_q)); // R7

endmodule

// File: rtl/wc_addr_mux.sv
// Module: wc_addr_mux
// Picks the source of the address lines from the mode flag, the
// in-command flag and the first-strobe window.
// Assumes the count and fields it reads are already registered.
module wc_addr_mux #(
    parameter int FIELD_W = 5
) (
    input  logic               mode_i,
    input  logic               in_cmd_n,
    input  logic               data_stb,
    input  logic               first_i,
    input  logic [FIELD_W-1:0] wc_i,
    input  logic [FIELD_W-1:0] cnt_i,
    output logic [FIELD_W-1:0] addr_o
);
    import wc_addr_pkg::*;

    localparam logic [FIELD_W-1:0] ONE = {{(FIELD_W-1){1'b0}}, 1'b1};

    addr_sel_e          sel;
    logic [FIELD_W-1:0] cnt_next;

    // Next-count view, wrapping at the field width
    always_comb begin
        cnt_next = cnt_i + ONE;
    end

    // Source selection: mode first, then command phase, then plain count
    always_comb begin
        if (mode_i) begin
            sel = SEL_CMD_WC;
        end else if (!in_cmd_n) begin
            sel = (first_i && data_stb) ? SEL_CMD_WC : SEL_CNT_NEXT;
        end else begin
            sel = SEL_CNT;
        end
    end

    // Drive the address lines from the selected source
    always_comb begin
        unique case (sel)
            SEL_CMD_WC:   addr_o = wc_i;
            SEL_CNT_NEXT: addr_o = cnt_next;
            default:      addr_o = cnt_i;
        endcase
    end

    always_comb begin
        AST_SEL_MODE_WINS: assert (!mode_i || addr_o == wc_i); // R3
    end

endmodule

// File: rtl/wc_addr_gen.sv
// Module: wc_addr_gen
// Word-count address generator for a remote terminal's subsystem memory.
// Ties together the field latch, the word counter and the output mux.
// Assumes a single clock, synchronous active-low reset, and pulse inputs
// that are one cycle wide.
module wc_addr_gen #(
    parameter int FIELD_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msg_start,
    input  logic               data_stb,
    input  logic               in_cmd_n,
    input  logic [FIELD_W-1:0] sa_i,
    input  logic [FIELD_W-1:0] wc_i,
    output logic [FIELD_W-1:0] addr_o
);

    logic [FIELD_W-1:0] wc_q;
    logic               mode_q;
    logic [FIELD_W-1:0] cnt_q;
    logic               first_q;

    wc_field_latch #(.FIELD_W(FIELD_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_start (msg_start),
        .sa_i      (sa_i),
        .wc_i      (wc_i),
        .wc_q      (wc_q),
        .mode_q    (mode_q)
    );

    wc_word_counter #(.FIELD_W(FIELD_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_start (msg_start),
        .data_stb  (data_stb),
        .cnt_q     (cnt_q),
        .first_q   (first_q)
    );

    wc_addr_mux #(.FIELD_W(FIELD_W)) u_mux (
        .mode_i    (mode_q),
        .in_cmd_n  (in_cmd_n),
        .data_stb  (data_stb),
        .first_i   (first_q),
        .wc_i      (wc_q),
        .cnt_i     (cnt_q),
        .addr_o    (addr_o)
    );

    AST_MODE_PORT_WC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(msg_start) && ((&$past(sa_i)) || !(|$past(sa_i))))
            |-> addr_o == $past(wc_i)); // R3

    AST_FIRST_STB_SHOWS_WC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(msg_start) && !$past(data_stb) && data_stb && !in_cmd_n && !msg_start)
            |-> addr_o == $past(wc_i)); // R4

    AST_START_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(msg_start) && !mode_q && in_cmd_n) |-> addr_o == '0); // R7

endmodule

// File: tb/wc_addr_gen_tb.sv
module wc_addr_gen_tb;

    localparam int W   = 5;
    localparam int MAX = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         msg_start = 1'b0;
    logic         data_stb = 1'b0;
    logic         in_cmd_n = 1'b1;
    logic [W-1:0] sa_i = '0;
    logic [W-1:0] wc_i = '0;
    logic [W-1:0] addr_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference model state
    int  m_wc, m_cnt;
    bit  m_mode, m_first;

    wc_addr_gen #(.FIELD_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .data_stb(data_stb),
        .in_cmd_n(in_cmd_n), .sa_i(sa_i), .wc_i(wc_i), .addr_o(addr_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: addr_o=%0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_addr();
        if (m_mode) return m_wc;
        if (!in_cmd_n) return (m_first && data_stb) ? m_wc : (m_cnt + 1) % MAX;
        return m_cnt;
    endfunction

    function automatic string exp_tag();
        if (m_mode) return "R3";
        if (!in_cmd_n) return (m_first && data_stb) ? "R4" : ((m_cnt == MAX-1) ? "R8" : "R5");
        return (m_cnt == 0) ? "R7" : "R6";
    endfunction

    task automatic check_both();
        in_cmd_n = 1'b1; #2; chk(exp_tag(), addr_o, exp_addr());
        in_cmd_n = 1'b0; #2; chk(exp_tag(), addr_o, exp_addr());
    endtask

    task automatic start_msg(input int sa, input int wc, input bit with_stb);
        @(negedge clk);
        msg_start = 1'b1; data_stb = with_stb;
        sa_i = W'(sa); wc_i = W'(wc);
        @(posedge clk);
        m_wc = wc; m_cnt = 0; m_first = 1;
        m_mode = (sa == 0) || (sa == MAX-1);
        @(negedge clk);
        msg_start = 1'b0; data_stb = 1'b0;
        sa_i = ~W'(sa); wc_i = ~W'(wc);   // R2: later field changes must not matter
        #2;
    endtask

    task automatic strobe();
        @(negedge clk);
        data_stb = 1'b1; in_cmd_n = 1'b0;
        #2; chk(exp_tag(), addr_o, exp_addr());
        @(posedge clk);
        if (m_first) m_first = 0; else m_cnt = (m_cnt + 1) % MAX;
        @(negedge clk);
        data_stb = 1'b0;
        #2; check_both();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #2;
        chk("R1", addr_o, 0);                  // reset state
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk("R1", addr_o, 0);

        // R2: fields held after start while inputs change
        start_msg(9, 13, 0);
        in_cmd_n = 1'b0; #2; chk("R2", addr_o, 1);
        sa_i = 5'd0; wc_i = 5'd27; #2; chk("R2", addr_o, 1);
        strobe();                               // first strobe sampled as R4
        in_cmd_n = 1'b1; #2; chk("R2", addr_o, 0);

        // R9: start and strobe together; window stays open
        start_msg(6, 21, 1);
        in_cmd_n = 1'b1; #2; chk("R9", addr_o, 0);
        @(negedge clk); data_stb = 1'b1; in_cmd_n = 1'b0;
        #2; chk("R9", addr_o, 21);
        @(posedge clk); m_first = 0;
        @(negedge clk); data_stb = 1'b0; in_cmd_n = 1'b1;
        #2; chk("R9", addr_o, 0);

        // Sweep: all subaddresses, several word counts, long messages
        for (int sa = 0; sa < MAX; sa++) begin
            for (int k = 0; k < 3; k++) begin
                int wc;
                int nst;
                wc  = (sa * 7 + k * 11 + 3) % MAX;
                nst = (k == 2) ? MAX + 3 : 4 + k;
                start_msg(sa, wc, 0);
                check_both();
                for (int s = 0; s < nst; s++) strobe();
            end
        end

        // R8: explicit wrap check after 33 strobes on ordinary subaddress
        start_msg(12, 5, 0);
        for (int s = 0; s < MAX + 1; s++) strobe();
        in_cmd_n = 1'b1; #2; chk("R8", addr_o, 0);
        in_cmd_n = 1'b0; #2; chk("R8", addr_o, 1);
        for (int s = 0; s < MAX - 1; s++) strobe();
        in_cmd_n = 1'b1; #2; chk("R8", addr_o, MAX - 1);
        in_cmd_n = 1'b0; #2; chk("R8", addr_o, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule